// File: doc/BRIEF.md
# Host Mailbox Status and Interrupt Register Bank

This block is a small 16-bit register bank on an external host processor bus. It sits beside a pair of mailboxes. The out-mailbox carries data from the local side to the host, and the in-mailbox carries data from the host to the local side. The block does not store mailbox data. It tracks whether the out-mailbox holds an unread message and whether the in-mailbox is empty. It also raises a level interrupt toward the host when an enabled condition is present.

The host reaches three registers through a 4-bit bank select and a 2-bit address:

- **Control register.** Holds a 2-bit code that picks a hold-margin delay for the bus signals. The code is only stored and presented on an output; no delay element is built here.
- **Interrupt-enable register.** Holds one enable bit per condition.
- **Status register.** Holds the two flags:
  - The in-mailbox empty flag is not stored. It is derived from the in-mailbox filled level supplied by the mailbox logic.
  - The out-mailbox filled flag is set by a one-cycle pulse from the local side. The host clears it by writing a one.

Reads are registered, so read data appears one cycle after read enable.

Top module: `hostmb_regs`

## Requirements
- R1: After reset the control register reads 0x0000, the interrupt-enable register reads 0x0000, the status register reads 0x0002 while the in-mailbox is not filled, and both `irq` and `rdata` are 0.
- R2: With bank select 4'b0001, address 2'b00 selects control, 2'b01 selects interrupt enable and 2'b10 selects status. Read data is registered: it appears in the cycle after a cycle with `cs` and `re` high, and it is 0x0000 after any cycle without a read.
- R3: Control bits [1:0] store the hold-margin code (00 = 5 ns, 01 = 3 ns, 10 = 1 ns, 11 = 0 ns). The code is presented on `hold_code` from the cycle after the write, and control bits [15:2] read as zero.
- R4: Interrupt-enable bit 1 enables the in-mailbox-empty condition and bit 0 enables the out-mailbox-filled condition. Interrupt-enable bits [15:2] read as zero.
- R5: Status bit 1 always equals the inverse of `imb_full`.
- R6: A one-cycle pulse on `omb_wr` sets status bit 0 in the next cycle, and the bit then stays 1 until it is cleared.
- R7: A host write to the status register with wdata bit 0 = 1 clears status bit 0. Writing 0 to bit 0 leaves it unchanged, and writes to bit 1 have no effect.
- R8: When an `omb_wr` pulse and a clearing status write occur in the same cycle, status bit 0 ends up 1.
- R9: `irq` is an active-high level equal to (enable[1] AND status[1]) OR (enable[0] AND status[0]), taken one cycle after those register values.
- R10: Reads of address 2'b11, or of any bank select other than 4'b0001, return 0x0000, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| we | input | 1 | Write enable |
| re | input | 1 | Read enable |
| bank | input | 4 | Bank select |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| omb_wr | input | 1 | Local-side out-mailbox write pulse |
| imb_full | input | 1 | In-mailbox filled level |
| irq | output | 1 | Registered interrupt level |
| hold_code | output | 2 | Stored hold-margin delay code |

## Verification
Reads are swept over all 64 pairs of bank select and address. This separates the three mapped registers from the unmapped ones and catches any decode that ignores bank bits. A write of all ones to every unmapped pair shows whether any register leaks a write. The interrupt is tried over all 16 combinations of the two enables and the two flags, which separates a correct AND-OR from one with swapped or missing terms. A single step checks its one-cycle lag. Status writes with 0x0000, 0xFFFE, 0x0001 and a clear coinciding with a set pulse tell write-one-to-clear apart from plain write, from write-zero-to-clear and from clear-wins.

// File: rtl/hostmb_pkg.sv
`timescale 1ns/1ps
package hostmb_pkg;

    typedef enum logic [1:0] {
        HOLD_5NS = 2'b00,
        HOLD_3NS = 2'b01,
        HOLD_1NS = 2'b10,
        HOLD_0NS = 2'b11
    } hold_sel_e;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'b00,
        SEL_INTE = 2'b01,
        SEL_STAT = 2'b10,
        SEL_NONE = 2'b11
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        logic     rd;
        reg_sel_e sel;
    } bus_op_t;

    localparam int NUM_SRC = 2;
    localparam int SRC_OMB = 0;
    localparam int SRC_IMB = 1;

    function automatic logic is_mapped(reg_sel_e s);
        return s != SEL_NONE;
    endfunction

endpackage

// File: rtl/hostmb_decode.sv
`timescale 1ns/1ps
module hostmb_decode
    import hostmb_pkg::*;
#(
    parameter int BANK_W = 4,
    parameter int ADDR_W = 2,
    parameter logic [BANK_W-1:0] BANK_ID = 1
) (
    input  logic              cs,
    input  logic              we,
    input  logic              re,
    input  logic [BANK_W-1:0] bank,
    input  logic [ADDR_W-1:0] addr,
    output bus_op_t           op
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_INTE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2);

    reg_sel_e sel;

    always_comb begin
        sel = SEL_NONE;
        if (cs && bank == BANK_ID) begin
            if (addr == A_CTRL)      sel = SEL_CTRL;
            else if (addr == A_INTE) sel = SEL_INTE;
            else if (addr == A_STAT) sel = SEL_STAT;
        end
    end

    assign op.sel = sel;
    assign op.wr  = cs && we && is_mapped(sel);
    assign op.rd  = cs && re;
endmodule

// File: rtl/hostmb_cfg.sv
`timescale 1ns/1ps
module hostmb_cfg
    import hostmb_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int N_SRC  = NUM_SRC
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_op_t           op,
    input  logic [DATA_W-1:0] wdata,
    output hold_sel_e         hold,
    output logic [N_SRC-1:0]  en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= HOLD_5NS;
            en   <= '0;
        end else if (op.wr) begin
            if (op.sel == SEL_CTRL) hold <= hold_sel_e'(wdata[1:0]);
            if (op.sel == SEL_INTE) en   <= wdata[N_SRC-1:0];
        end
    end
endmodule

// File: rtl/hostmb_flags.sv
`timescale 1ns/1ps
module hostmb_flags
    import hostmb_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_op_t          op,
    input  logic             clr_bit,
    input  logic             omb_set,
    input  logic             imb_full,
    output logic [N_SRC-1:0] flag
);
    logic omb_q;
    logic omb_clr;

    assign omb_clr = op.wr && op.sel == SEL_STAT && clr_bit;

    // set has priority over a coincident host clear
    always_ff @(posedge clk) begin
        if (rst)          omb_q <= 1'b0;
        else if (omb_set) omb_q <= 1'b1;
        else if (omb_clr) omb_q <= 1'b0;
    end

    always_comb begin
        flag          = '0;
        flag[SRC_OMB] = omb_q;
        flag[SRC_IMB] = ~imb_full;
    end
endmodule

// File: rtl/hostmb_irq.sv
`timescale 1ns/1ps
module hostmb_irq
    import hostmb_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] flag,
    input  logic [N_SRC-1:0] en,
    output logic             irq
);
    logic [N_SRC-1:0] hit;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign hit[i] = flag[i] & en[i];
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |hit;
    end
endmodule

// File: rtl/hostmb_regs.sv
`timescale 1ns/1ps
module hostmb_regs
    import hostmb_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BANK_W = 4,
    parameter int ADDR_W = 2,
    parameter logic [BANK_W-1:0] BANK_ID = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              we,
    input  logic              re,
    input  logic [BANK_W-1:0] bank,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              omb_wr,
    input  logic              imb_full,
    output logic              irq,
    output logic [1:0]        hold_code
);
    bus_op_t            op;
    hold_sel_e          hold;
    logic [NUM_SRC-1:0] irq_en;
    logic [NUM_SRC-1:0] stat_flags;
    logic [DATA_W-1:0]  rd_mux;

    hostmb_decode #(.BANK_W(BANK_W), .ADDR_W(ADDR_W), .BANK_ID(BANK_ID)) u_dec (
        .cs(cs), .we(we), .re(re), .bank(bank), .addr(addr), .op(op)
    );

    hostmb_cfg #(.DATA_W(DATA_W), .N_SRC(NUM_SRC)) u_cfg (
        .clk(clk), .rst(rst), .op(op), .wdata(wdata), .hold(hold), .en(irq_en)
    );

    hostmb_flags #(.N_SRC(NUM_SRC)) u_flags (
        .clk(clk), .rst(rst), .op(op), .clr_bit(wdata[SRC_OMB]),
        .omb_set(omb_wr), .imb_full(imb_full), .flag(stat_flags)
    );

    hostmb_irq #(.N_SRC(NUM_SRC)) u_irq (
        .clk(clk), .rst(rst), .flag(stat_flags), .en(irq_en), .irq(irq)
    );

    always_comb begin
        case (op.sel)
            SEL_CTRL: rd_mux = DATA_W'(hold);
            SEL_INTE: rd_mux = DATA_W'(irq_en);
            SEL_STAT: rd_mux = DATA_W'(stat_flags);
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (op.rd) rdata <= rd_mux;
        else            rdata <= '0;
    end

    assign hold_code = hold;
endmodule

// File: rtl/hostmb_regs_chk.sv
`timescale 1ns/1ps
module hostmb_regs_chk #(
    parameter int DATA_W = 16,
    parameter int BANK_W = 4,
    parameter int ADDR_W = 2,
    parameter logic [BANK_W-1:0] BANK_ID = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              cs,
    input logic              we,
    input logic              re,
    input logic [BANK_W-1:0] bank,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              omb_wr,
    input logic              imb_full,
    input logic              irq,
    input logic [1:0]        hold_code,
    input logic [1:0]        stat_flags,
    input logic [1:0]        irq_en
);
    logic mine, wr_ctrl, clr_stat, bad_rd;
    assign mine     = cs && bank == BANK_ID;
    assign wr_ctrl  = mine && we && addr == ADDR_W'(0);
    assign clr_stat = mine && we && addr == ADDR_W'(2) && wdata[0];
    assign bad_rd   = cs && re && (bank != BANK_ID || addr == ADDR_W'(3));

    p_rdata_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !(cs && re) |=> rdata == '0);

    p_hold_code_r3: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> hold_code == $past(wdata[1:0]));

    p_imb_empty_r5: assert property (@(posedge clk) disable iff (rst)
        stat_flags[1] == !imb_full);

    p_omb_set_r6: assert property (@(posedge clk) disable iff (rst)
        omb_wr |=> stat_flags[0]);

    p_omb_clear_r7: assert property (@(posedge clk) disable iff (rst)
        clr_stat && !omb_wr |=> !stat_flags[0]);

    p_omb_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !clr_stat && !omb_wr |=> $stable(stat_flags[0]));

    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        clr_stat && omb_wr |=> stat_flags[0]);

    p_irq_level_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq == $past((irq_en[1] & stat_flags[1]) | (irq_en[0] & stat_flags[0])));

    p_unmapped_read_r10: assert property (@(posedge clk) disable iff (rst)
        bad_rd |=> rdata == '0);
endmodule

bind hostmb_regs hostmb_regs_chk #(
    .DATA_W(DATA_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W), .BANK_ID(BANK_ID)
) u_chk (
    .clk(clk), .rst(rst), .cs(cs), .we(we), .re(re), .bank(bank), .addr(addr),
    .wdata(wdata), .rdata(rdata), .omb_wr(omb_wr), .imb_full(imb_full),
    .irq(irq), .hold_code(hold_code), .stat_flags(stat_flags), .irq_en(irq_en)
);

// File: tb/hostmb_regs_tb.sv
`timescale 1ns/1ps
module hostmb_regs_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs = 0, we = 0, re = 0, omb_wr = 0, imb_full = 0;
    logic [3:0]  bank = '0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;
    logic [1:0]  hold_code;
    int total = 0, bad = 0;
    logic [15:0] d;

    always #5 clk = ~clk;

    hostmb_regs u_dut (
        .clk(clk), .rst(rst), .cs(cs), .we(we), .re(re), .bank(bank), .addr(addr),
        .wdata(wdata), .rdata(rdata), .omb_wr(omb_wr), .imb_full(imb_full),
        .irq(irq), .hold_code(hold_code)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] b, input logic [1:0] a, input logic [15:0] v);
        @(negedge clk);
        cs = 1; we = 1; bank = b; addr = a; wdata = v;
        @(negedge clk);
        cs = 0; we = 0; wdata = '0;
    endtask

    task automatic rd(input logic [3:0] b, input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        cs = 1; re = 1; bank = b; addr = a;
        @(negedge clk);
        cs = 0; re = 0;
        v = rdata;
    endtask

    task automatic pulse();
        @(negedge clk);
        omb_wr = 1;
        @(negedge clk);
        omb_wr = 0;
    endtask

    function automatic logic [15:0] expect_rd(input logic [3:0] b, input logic [1:0] a,
                                             input logic [15:0] c, input logic [15:0] e,
                                             input logic [15:0] s);
        if (b != 4'd1) return 16'h0;
        case (a)
            2'd0: return c;
            2'd1: return e;
            2'd2: return s;
            default: return 16'h0;
        endcase
    endfunction

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 rdata", rdata, 16'h0);
        check("R1 irq", {15'h0, irq}, 16'h0);
        check("R1 hold_code", {14'h0, hold_code}, 16'h0);

        // R2 R10 R1: read sweep over every bank/address pair
        for (int b = 0; b < 16; b++)
            for (int a = 0; a < 4; a++) begin
                rd(4'(b), 2'(a), d);
                check("R2/R10 read sweep", d, expect_rd(4'(b), 2'(a), 16'h0, 16'h0, 16'h2));
            end
        @(negedge clk);
        check("R2 rdata idle", rdata, 16'h0);

        // R10: writes of all ones to unmapped pairs change nothing
        for (int b = 0; b < 16; b++)
            for (int a = 0; a < 4; a++)
                if (b != 1 || a == 3) wr(4'(b), 2'(a), 16'hFFFF);
        pulse();
        wr(4'd1, 2'd2, 16'h0001);
        for (int b = 0; b < 16; b++)
            for (int a = 0; a < 4; a++)
                if (b != 1 || a == 3) wr(4'(b), 2'(a), 16'hFFFF);
        rd(4'd1, 2'd0, d); check("R10 ctrl untouched", d, 16'h0);
        rd(4'd1, 2'd1, d); check("R10 inte untouched", d, 16'h0);
        rd(4'd1, 2'd2, d); check("R10 stat untouched", d, 16'h2);

        // R3: each hold code, upper bits read zero
        for (int c = 0; c < 4; c++) begin
            wr(4'd1, 2'd0, 16'hFFFC | 16'(c));
            rd(4'd1, 2'd0, d);
            check("R3 ctrl read", d, 16'(c));
            check("R3 hold_code", {14'h0, hold_code}, 16'(c));
        end

        // R4: enable bits, upper bits read zero
        wr(4'd1, 2'd1, 16'hFFFF);
        rd(4'd1, 2'd1, d); check("R4 inte read", d, 16'h3);
        wr(4'd1, 2'd1, 16'h0000);

        // R5: in-mailbox empty follows imb_full
        @(negedge clk); imb_full = 1;
        rd(4'd1, 2'd2, d); check("R5 imb full", d, 16'h0);
        @(negedge clk); imb_full = 0;
        rd(4'd1, 2'd2, d); check("R5 imb empty", d, 16'h2);

        // R6: set by pulse, holds
        pulse();
        rd(4'd1, 2'd2, d); check("R6 set", d, 16'h3);
        repeat (5) @(negedge clk);
        rd(4'd1, 2'd2, d); check("R6 held", d, 16'h3);

        // R7: write-one-to-clear only
        wr(4'd1, 2'd2, 16'h0000);
        rd(4'd1, 2'd2, d); check("R7 write zero", d, 16'h3);
        wr(4'd1, 2'd2, 16'hFFFE);
        rd(4'd1, 2'd2, d); check("R7 write bit1", d, 16'h3);
        wr(4'd1, 2'd2, 16'h0001);
        rd(4'd1, 2'd2, d); check("R7 clear", d, 16'h2);
        @(negedge clk); imb_full = 1;
        wr(4'd1, 2'd2, 16'h0002);
        rd(4'd1, 2'd2, d); check("R7 bit1 ignored", d, 16'h0);
        @(negedge clk); imb_full = 0;

        // R8: set wins over a coincident clear
        @(negedge clk);
        cs = 1; we = 1; bank = 4'd1; addr = 2'd2; wdata = 16'h0001; omb_wr = 1;
        @(negedge clk);
        cs = 0; we = 0; wdata = '0; omb_wr = 0;
        rd(4'd1, 2'd2, d); check("R8 set wins", d, 16'h3);
        wr(4'd1, 2'd2, 16'h0001);

        // R9: full sweep of enables and flags
        for (int e = 0; e < 4; e++)
            for (int i = 0; i < 2; i++)
                for (int o = 0; o < 2; o++) begin
                    wr(4'd1, 2'd2, 16'h0001);
                    if (o == 1) pulse();
                    @(negedge clk); imb_full = i[0];
                    wr(4'd1, 2'd1, 16'(e));
                    repeat (2) @(negedge clk);
                    check("R9 irq sweep", {15'h0, irq},
                          16'((e[1] & ~i[0]) | (e[0] & o[0])));
                end

        // R9: one-cycle latency
        @(negedge clk); imb_full = 1;
        wr(4'd1, 2'd2, 16'h0001);
        wr(4'd1, 2'd1, 16'h0001);
        repeat (2) @(negedge clk);
        check("R9 irq low before", {15'h0, irq}, 16'h0);
        pulse();
        check("R9 irq lag", {15'h0, irq}, 16'h0);
        @(negedge clk);
        check("R9 irq rises", {15'h0, irq}, 16'h1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule